// File: doc/BRIEF.md
# Security-Banked System Handler Status Register

This block holds the active, pending and enable state of the system exception handlers. It sits inside an interrupt controller that separates Secure and Non-secure states, and it presents that state as one 32-bit word on a simple read/write port. Each access carries a security attribute. That attribute decides where the access lands: a Secure copy of the handler bits, a Non-secure copy, or bits that both states share. Some of the shared bits are hidden from Non-secure accesses. Others are hidden only while bus fault, hard fault and NMI stay with the Secure state.

A separate routing input (`ns_route_i`) hands bus fault, hard fault and NMI to the Non-secure state. While it is set, the shared bus-fault bits and the NMI active bit become visible to Non-secure accesses. The NMI active bit and the Non-secure hard-fault active bit can be cleared by software only through a narrow path: a Non-secure-attributed write, issued while the CPU runs Secure, with the routing bit set, writing a zero to that bit. Nothing in software can set them. They are set only by exception-entry strobes. All state goes to the priority logic as separate vectors. A one-cycle pulse follows every write so that the priority logic re-evaluates.

Top module: `hsr_top`

## Requirements
- R1: After reset every state bit is zero, both read views return 0 and `reeval_o` is low.
- R2: The memory-fault, usage-fault, supervisor-call, pendable-service and system-tick bits are banked. These are the active bits 0, 3, 7, 10 and 11, the pending bits 13 (memory), 12 (usage) and 15 (supervisor call), and the enable bits 16 (memory) and 18 (usage). An access with `sec_i`=1 reads and writes the Secure copy. An access with `sec_i`=0 reads and writes the Non-secure copy.
- R3: The secure-fault bits are one shared copy: active at bit 4, enable at bit 19, pending at bit 20. Secure accesses read and write them. Non-secure accesses read them as zero and leave them unchanged.
- R4: The bus-fault bits are one shared copy: active at bit 1, pending at bit 14, enable at bit 17. They are read and written only when `sec_i`=1 or `ns_route_i`=1. Otherwise they read as zero and a write leaves them unchanged.
- R5: NMI active appears at bit 5 of the read data only when `sec_i`=1 or `ns_route_i`=1.
- R6: A Secure write never changes the Secure hard-fault active bit, which reads at bit 2 in the Secure view. In the Secure view, bit 21 reads zero and Secure writes to it are ignored.
- R7: A Non-secure write sets or clears the Non-secure hard-fault pending bit, which reads at bit 21 in the Non-secure view.
- R8: A write clears NMI active only when `sec_i`=0, `cpu_sec_i`=1, `ns_route_i`=1 and write-data bit 5 is 0. No write ever sets it.
- R9: The Non-secure hard-fault active bit, which reads at bit 2 in the Non-secure view, follows the rule of R8 with write-data bit 2. No write ever sets it. Secure writes never touch it.
- R10: Debug-monitor active (bit 8) is one unbanked bit that any access reads and writes.
- R11: Reserved bits 6, 9 and 22 to 31 always read as zero.
- R12: A write changes state on the clock edge that samples `wr_i`. `reeval_o` is high for exactly the cycle that follows each write edge.
- R13: `nmi_set_i`, `hf_s_set_i` and `hf_ns_set_i` set NMI active, Secure hard-fault active and Non-secure hard-fault active on the next edge. A set strobe wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| sec_i | input | 1 | Security attribute of the access (1 = Secure) |
| cpu_sec_i | input | 1 | CPU currently in Secure state |
| ns_route_i | input | 1 | Bus fault, hard fault and NMI routed to Non-secure |
| nmi_set_i | input | 1 | NMI entry, sets NMI active |
| hf_s_set_i | input | 1 | Secure hard-fault entry |
| hf_ns_set_i | input | 1 | Non-secure hard-fault entry |
| rdata_o | output | DW | Read data for the current attribute |
| s_act_o | output | 6 | Secure active bits, one per banked handler: memory, usage, svc, pendsv, systick, hard |
| s_pend_o | output | 6 | Secure pending bits, same handler order |
| s_en_o | output | 6 | Secure enable bits, same handler order |
| ns_act_o | output | 6 | Non-secure active bits |
| ns_pend_o | output | 6 | Non-secure pending bits |
| ns_en_o | output | 6 | Non-secure enable bits |
| bus_o | output | 3 | Bus fault {enable, pending, active} |
| sf_o | output | 3 | Secure fault {enable, pending, active} |
| nmi_act_o | output | 1 | NMI active |
| dbg_act_o | output | 1 | Debug-monitor active |
| reeval_o | output | 1 | One-cycle pulse that asks for priority re-evaluation |

## Verification
The bench builds the block with its default data width of 32. At that width every architected bit position and every reserved position of the word can be reached. The stimulus table fills and drains each bank with all-ones and all-zeros words under different attribute and routing combinations. Each readback shows which copy a write landed in. Directed sequences then cover the two clear-only active bits and each of the four gating conditions that protect them.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int NH = 6;
  localparam int H_MEM = 0;
  localparam int H_USG = 1;
  localparam int H_SVC = 2;
  localparam int H_PSV = 3;
  localparam int H_TCK = 4;
  localparam int H_HRD = 5;

  localparam int B_BUS_ACT = 1;
  localparam int B_SF_ACT  = 4;
  localparam int B_NMI_ACT = 5;
  localparam int B_DBG_ACT = 8;
  localparam int B_BUS_PND = 14;
  localparam int B_BUS_EN  = 17;
  localparam int B_SF_EN   = 19;
  localparam int B_SF_PND  = 20;

  function automatic int act_pos(int h);
    case (h)
      H_MEM:   return 0;
      H_USG:   return 3;
      H_SVC:   return 7;
      H_PSV:   return 10;
      H_TCK:   return 11;
      default: return 2;
    endcase
  endfunction

  function automatic bit has_pend(int h);
    return (h == H_MEM) || (h == H_USG) || (h == H_SVC) || (h == H_HRD);
  endfunction

  function automatic int pend_pos(int h);
    case (h)
      H_MEM:   return 13;
      H_USG:   return 12;
      H_SVC:   return 15;
      default: return 21;
    endcase
  endfunction

  function automatic bit has_en(int h);
    return (h == H_MEM) || (h == H_USG);
  endfunction

  function automatic int en_pos(int h);
    return (h == H_MEM) ? 16 : 18;
  endfunction
endpackage

// File: rtl/hsr_bank.sv
module hsr_bank
  import hsr_pkg::*;
#(
  parameter int DW = 32,
  parameter bit HF_PEND_WR = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          hf_set_i,
  input  logic          hf_clr_i,
  output logic [NH-1:0] act_o,
  output logic [NH-1:0] pend_o,
  output logic [NH-1:0] en_o,
  output logic [DW-1:0] view_o
);
  logic unused_wd;
  assign unused_wd = ^wdata_i;

  for (genvar h = 0; h < NH; h++) begin : g_h
    if (h == H_HRD) begin : g_hact
      logic a_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       a_q <= 1'b0;
        else if (hf_set_i) a_q <= 1'b1;
        else if (hf_clr_i) a_q <= 1'b0;
      end
      assign act_o[h] = a_q;
      // Only the set/clear strobes may move this bit (R6, R9, R13)
      p_hf_act_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hf_set_i && !hf_clr_i) |=> $stable(a_q));
    end else begin : g_act
      logic a_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   a_q <= 1'b0;
        else if (we_i) a_q <= wdata_i[act_pos(h)];
      end
      assign act_o[h] = a_q;
    end

    if (has_pend(h) && (h != H_HRD || HF_PEND_WR)) begin : g_pend
      logic p_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   p_q <= 1'b0;
        else if (we_i) p_q <= wdata_i[pend_pos(h)];
      end
      assign pend_o[h] = p_q;
    end else begin : g_nopend
      assign pend_o[h] = 1'b0;
    end

    if (has_en(h)) begin : g_en
      logic e_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   e_q <= 1'b0;
        else if (we_i) e_q <= wdata_i[en_pos(h)];
      end
      assign en_o[h] = e_q;
    end else begin : g_noen
      assign en_o[h] = 1'b0;
    end
  end

  always_comb begin
    view_o = '0;
    for (int h = 0; h < NH; h++) begin
      view_o[act_pos(h)] = act_o[h];
      if (has_pend(h)) view_o[pend_pos(h)] = pend_o[h];
      if (has_en(h))   view_o[en_pos(h)]   = en_o[h];
    end
  end
endmodule

// File: rtl/hsr_shared.sv
module hsr_shared
  import hsr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sec_i,
  input  logic          route_i,
  input  logic          nmi_set_i,
  input  logic          nmi_clr_i,
  output logic [2:0]    bus_o,
  output logic [2:0]    sf_o,
  output logic          nmi_o,
  output logic          dbg_o,
  output logic [DW-1:0] view_o
);
  logic [2:0] bus_q, sf_q;
  logic       nmi_q, dbg_q;
  logic       bus_vis;
  logic       unused_wd;

  assign unused_wd = ^wdata_i;
  assign bus_vis   = sec_i | route_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q <= '0;
      sf_q  <= '0;
      dbg_q <= 1'b0;
    end else if (we_i) begin
      dbg_q <= wdata_i[B_DBG_ACT];
      if (bus_vis)
        bus_q <= {wdata_i[B_BUS_EN], wdata_i[B_BUS_PND], wdata_i[B_BUS_ACT]};
      if (sec_i)
        sf_q <= {wdata_i[B_SF_EN], wdata_i[B_SF_PND], wdata_i[B_SF_ACT]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        nmi_q <= 1'b0;
    else if (nmi_set_i) nmi_q <= 1'b1;
    else if (nmi_clr_i) nmi_q <= 1'b0;
  end

  always_comb begin
    view_o = '0;
    view_o[B_DBG_ACT] = dbg_q;
    if (bus_vis) begin
      view_o[B_BUS_ACT] = bus_q[0];
      view_o[B_BUS_PND] = bus_q[1];
      view_o[B_BUS_EN]  = bus_q[2];
      view_o[B_NMI_ACT] = nmi_q;
    end
    if (sec_i) begin
      view_o[B_SF_ACT] = sf_q[0];
      view_o[B_SF_PND] = sf_q[1];
      view_o[B_SF_EN]  = sf_q[2];
    end
  end

  assign bus_o = bus_q;
  assign sf_o  = sf_q;
  assign nmi_o = nmi_q;
  assign dbg_o = dbg_q;

  p_sf_ns_wi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sec_i) |=> $stable(sf_q));
  p_bus_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sec_i && !route_i) |=> $stable(bus_q));
  p_nmi_noset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_set_i |=> !$rose(nmi_q));
endmodule

// File: rtl/hsr_top.sv
module hsr_top
  import hsr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sec_i,
  input  logic          cpu_sec_i,
  input  logic          ns_route_i,
  input  logic          nmi_set_i,
  input  logic          hf_s_set_i,
  input  logic          hf_ns_set_i,
  output logic [DW-1:0] rdata_o,
  output logic [NH-1:0] s_act_o,
  output logic [NH-1:0] s_pend_o,
  output logic [NH-1:0] s_en_o,
  output logic [NH-1:0] ns_act_o,
  output logic [NH-1:0] ns_pend_o,
  output logic [NH-1:0] ns_en_o,
  output logic [2:0]    bus_o,
  output logic [2:0]    sf_o,
  output logic          nmi_act_o,
  output logic          dbg_act_o,
  output logic          reeval_o
);
  logic [DW-1:0] s_view, ns_view, sh_view;
  logic          alias_ok, nmi_clr, hf_ns_clr, reeval_q;

  // Clear-only path: NS alias written while the CPU runs Secure
  assign alias_ok  = wr_i & ~sec_i & cpu_sec_i & ns_route_i;
  assign nmi_clr   = alias_ok & ~wdata_i[B_NMI_ACT];
  assign hf_ns_clr = alias_ok & ~wdata_i[act_pos(H_HRD)];

  hsr_bank #(.DW(DW), .HF_PEND_WR(1'b0)) u_sbank (
    .clk_i, .rst_ni,
    .we_i(wr_i & sec_i), .wdata_i,
    .hf_set_i(hf_s_set_i), .hf_clr_i(1'b0),
    .act_o(s_act_o), .pend_o(s_pend_o), .en_o(s_en_o), .view_o(s_view)
  );

  hsr_bank #(.DW(DW), .HF_PEND_WR(1'b1)) u_nsbank (
    .clk_i, .rst_ni,
    .we_i(wr_i & ~sec_i), .wdata_i,
    .hf_set_i(hf_ns_set_i), .hf_clr_i(hf_ns_clr),
    .act_o(ns_act_o), .pend_o(ns_pend_o), .en_o(ns_en_o), .view_o(ns_view)
  );

  hsr_shared #(.DW(DW)) u_shared (
    .clk_i, .rst_ni,
    .we_i(wr_i), .wdata_i,
    .sec_i, .route_i(ns_route_i),
    .nmi_set_i, .nmi_clr_i(nmi_clr),
    .bus_o, .sf_o, .nmi_o(nmi_act_o), .dbg_o(dbg_act_o), .view_o(sh_view)
  );

  assign rdata_o = (sec_i ? s_view : ns_view) | sh_view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reeval_q <= 1'b0;
    else         reeval_q <= wr_i;
  end
  assign reeval_o = reeval_q;

  p_reeval_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> reeval_o);
  p_reeval_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !reeval_o);
  p_nmi_hidden_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_i && !ns_route_i) |-> !rdata_o[B_NMI_ACT]);
  p_rsvd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[DW-1:22] == '0) && !rdata_o[6] && !rdata_o[9]);
endmodule

// File: tb/hsr_top_test.sv
module hsr_top_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [DW-1:0] wd = '0;
  logic          sec = 1'b0, cpu_sec = 1'b0, route = 1'b0;
  logic          nmi_set = 1'b0, hfs_set = 1'b0, hfns_set = 1'b0;
  logic [DW-1:0] rdata;
  logic [5:0]    s_act, s_pend, s_en, ns_act, ns_pend, ns_en;
  logic [2:0]    bus, sf;
  logic          nmi_act, dbg_act, reeval;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hsr_top #(.DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wd),
    .sec_i(sec), .cpu_sec_i(cpu_sec), .ns_route_i(route),
    .nmi_set_i(nmi_set), .hf_s_set_i(hfs_set), .hf_ns_set_i(hfns_set),
    .rdata_o(rdata), .s_act_o(s_act), .s_pend_o(s_pend), .s_en_o(s_en),
    .ns_act_o(ns_act), .ns_pend_o(ns_pend), .ns_en_o(ns_en),
    .bus_o(bus), .sf_o(sf), .nmi_act_o(nmi_act), .dbg_act_o(dbg_act),
    .reeval_o(reeval)
  );

  typedef struct packed {
    logic        w_sec;
    logic        cpu;
    logic        rt;
    logic [31:0] wdat;
    logic        r_sec;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 6;
  // R2 R3 R4 R10 R11: write then read back under a chosen attribute
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 32'h001F_FD9B},
    '{1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 32'h001F_FC9B},
    '{1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 32'h0025_BD89},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 32'h001D_BC99},
    '{1'b0, 1'b0, 1'b1, 32'h0002_4002, 1'b0, 32'h0002_4002},
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_0000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr_op(logic s, logic c, logic r, logic [31:0] d);
    @(negedge clk);
    sec = s; cpu_sec = c; route = r; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_at(logic s, logic r);
    sec = s; route = r;
    #1;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_at(1'b1, 1'b1); chk("R1 secure view", rdata, 0);
    rd_at(1'b0, 1'b0); chk("R1 ns view", rdata, 0);
    chk("R1 outputs", {s_act, ns_act, bus, sf, nmi_act, dbg_act, reeval}, 0);

    for (int i = 0; i < NV; i++) begin
      wr_op(VEC[i].w_sec, VEC[i].cpu, VEC[i].rt, VEC[i].wdat);
      rd_at(VEC[i].r_sec, VEC[i].rt);
      chk($sformatf("R2/R3/R4/R10 vector %0d", i), rdata, VEC[i].exp);
    end

    // R12 timing of write and re-evaluation pulse
    @(negedge clk);
    sec = 1'b1; route = 1'b0; wd = 32'h0000_0100; wr = 1'b1;
    #1 chk("R12 before edge", {31'd0, dbg_act}, 0);
    @(negedge clk);
    wr = 1'b0;
    chk("R12 after edge", {31'd0, dbg_act}, 1);
    chk("R12 pulse high", {31'd0, reeval}, 1);
    @(negedge clk);
    chk("R12 pulse low", {31'd0, reeval}, 0);

    // R13 NMI entry, R5 visibility
    pulse(nmi_set);
    chk("R13 nmi set", {31'd0, nmi_act}, 1);
    rd_at(1'b0, 1'b0); chk("R5 nmi hidden ns", {31'd0, rdata[5]}, 0);
    rd_at(1'b0, 1'b1); chk("R5 nmi shown routed", {31'd0, rdata[5]}, 1);
    rd_at(1'b1, 1'b0); chk("R5 nmi shown secure", {31'd0, rdata[5]}, 1);

    // R8 clear-only rule: each condition missing in turn
    wr_op(1'b0, 1'b0, 1'b1, 32'h0); chk("R8 cpu non-secure", {31'd0, nmi_act}, 1);
    wr_op(1'b0, 1'b1, 1'b0, 32'h0); chk("R8 not routed", {31'd0, nmi_act}, 1);
    wr_op(1'b1, 1'b1, 1'b1, 32'h0); chk("R8 secure attr", {31'd0, nmi_act}, 1);
    wr_op(1'b0, 1'b1, 1'b1, 32'h20); chk("R8 writes one", {31'd0, nmi_act}, 1);
    wr_op(1'b0, 1'b1, 1'b1, 32'h0); chk("R8 cleared", {31'd0, nmi_act}, 0);
    wr_op(1'b1, 1'b1, 1'b1, 32'h20); chk("R8 no set by write", {31'd0, nmi_act}, 0);

    // R9 non-secure hard-fault active
    pulse(hfns_set);
    rd_at(1'b0, 1'b0); chk("R9 ns hf active read", {31'd0, rdata[2]}, 1);
    wr_op(1'b1, 1'b1, 1'b1, 32'h0); chk("R9 secure write ignored", {31'd0, ns_act[5]}, 1);
    wr_op(1'b0, 1'b0, 1'b1, 32'h0); chk("R9 cpu non-secure", {31'd0, ns_act[5]}, 1);
    wr_op(1'b0, 1'b1, 1'b1, 32'h4); chk("R9 writes one", {31'd0, ns_act[5]}, 1);
    wr_op(1'b0, 1'b1, 1'b1, 32'h0); chk("R9 cleared", {31'd0, ns_act[5]}, 0);

    // R6 secure hard-fault bits
    pulse(hfs_set);
    wr_op(1'b1, 1'b1, 1'b0, 32'h0);
    rd_at(1'b1, 1'b0); chk("R6 secure hf act kept", {31'd0, rdata[2]}, 1);
    wr_op(1'b1, 1'b1, 1'b0, 32'hFFFF_FFFB);
    rd_at(1'b1, 1'b0); chk("R6 secure bit21 zero", {31'd0, rdata[21]}, 0);
    chk("R11 reserved bits", rdata & 32'hFFC0_0240, 0);

    // R7 non-secure hard-fault pending
    wr_op(1'b0, 1'b0, 1'b0, 32'h0020_0000);
    rd_at(1'b0, 1'b0); chk("R7 ns pend set", {31'd0, rdata[21]}, 1);
    wr_op(1'b0, 1'b0, 1'b0, 32'h0);
    rd_at(1'b0, 1'b0); chk("R7 ns pend clear", {31'd0, ns_pend[5]}, 0);

    // R13 set beats clear in the same cycle
    @(negedge clk);
    sec = 1'b0; cpu_sec = 1'b1; route = 1'b1; wd = 32'h0; wr = 1'b1; nmi_set = 1'b1;
    @(negedge clk);
    wr = 1'b0; nmi_set = 1'b0;
    chk("R13 set priority", {31'd0, nmi_act}, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule